// File: doc/BRIEF.md
# External Memory Interface Sequencer

This block puts two internal request spaces onto one external memory bus. The instruction/coefficient space (X) and the data space (Y) each present a request with an address, a direction and write data. The sequencer owns a 16-bit external address bus and a 16-bit bidirectional data bus, and only one space can use them at a time. When both spaces ask in the same cycle, the X access runs first and the Y access starts in the cycle straight after it.

Each access is steered to one of four external segments: low RAM, I/O, high RAM or ROM. The segment's active-low enable is driven for the length of the access. One address inside the I/O window also drives a separate peripheral select. Each segment has its own wait-state count. Each of the five selects can be set to assert half a clock period late, so slow and fast devices can share the bus. The memory-map boundaries are parameters. The configuration is loaded through two plain register-write strobes.

Top module: `emi_seq`

## Requirements
- R1: An X access always uses the ROM enable. A Y access uses the high-RAM enable when its address is at or above HIRAM_BASE (default 0x8000). It uses the I/O enable when the address lies in IO_BASE..IO_LAST (default 0x4000..0x40FF). Otherwise it uses the low-RAM enable. The enable bits are `seg_en_n[0]` low RAM, `[1]` I/O, `[2]` high RAM and `[3]` ROM, and all of them are active-low.
- R2: A Y access to PSEL_ADDR (default 0x40F0) drives `psel` active together with the I/O enable. No other access does. The select is active-low when control bit 5 is 0 and active-high when it is 1.
- R3: An access to a segment whose wait count is N keeps its enable active for exactly 1+N cycles. The requester's ready output is high in the last of those cycles. The wait register fields are low RAM [3:0], I/O [7:4], high RAM [11:8] and ROM [15:12].
- R4: When X and Y request in the same idle cycle, X is served first. The Y access begins in the cycle after the X access's last cycle, so Y's ready comes 1+N(Y) cycles after X's ready.
- R5: At most one segment enable is active at any time, and `x_rdy` and `y_rdy` are never high together.
- R6: Control bit k (0 low RAM, 1 I/O, 2 high RAM, 3 ROM, 4 peripheral select) delays that select's assertion to the falling clock edge in the first cycle of the access. With the bit clear, the select is active from the rising edge that starts the access.
- R7: During a write, `ext_we_n` is low and the bus carries the write data. During a read, `ext_we_n` is high, the bus is released, and the ready space's read data equals the bus value.
- R8: Reset leaves every enable inactive, `psel` high, `ext_we_n` high and both readies low. The wait counts and control bits are all zero: no wait states, no delays, active-low peripheral select.
- R9: `ext_addr` carries the requested address for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_wait_we | input | 1 | Load the wait-count register |
| cfg_ctl_we | input | 1 | Load the control register (bits 5:0) |
| x_req | input | 1 | X space request, held until ready |
| x_we | input | 1 | X access is a write |
| x_addr | input | 16 | X address |
| x_wdata | input | 16 | X write data |
| x_rdata | output | 16 | X read data, valid with x_rdy |
| x_rdy | output | 1 | X access completes this cycle |
| y_req | input | 1 | Y space request, held until ready |
| y_we | input | 1 | Y access is a write |
| y_addr | input | 16 | Y address |
| y_wdata | input | 16 | Y write data |
| y_rdata | output | 16 | Y read data, valid with y_rdy |
| y_rdy | output | 1 | Y access completes this cycle |
| ext_addr | output | 16 | External address bus |
| ext_data | inout | 16 | External bidirectional data bus |
| ext_we_n | output | 1 | External write strobe, active-low |
| seg_en_n | output | 4 | Segment enables, active-low |
| psel | output | 1 | Peripheral select, programmable polarity |

## Verification
Single accesses go to every segment and to addresses on both sides of each memory-map boundary. These separate a decode fault from a wait-count fault, because each segment is loaded with a different wait count. Simultaneous X and Y requests are tried with zero and non-zero wait counts. These show the order of service and the exact cycle in which Y follows X. Two different delay and polarity settings check the first half-cycle of each select on its own. This tells a missing delay apart from a delay on the wrong select, and a wrong polarity apart from a wrong decode.

// File: rtl/emi_pkg.sv
`timescale 1ns/1ps
// Shared types for the external memory interface sequencer.
// Assumes four external segments; the enum code is the enable bit index.
package emi_pkg;

    typedef enum logic [1:0] {
        SEG_LORAM = 2'd0,
        SEG_IO    = 2'd1,
        SEG_HIRAM = 2'd2,
        SEG_ROM   = 2'd3
    } seg_e;

    typedef enum logic {
        SP_X = 1'b0,
        SP_Y = 1'b1
    } space_e;

endpackage

// File: rtl/emi_cfg_regs.sv
`timescale 1ns/1ps
// Configuration holding registers: per-segment wait counts and the
// delay/polarity control bits. Assumes CTL_W <= CFG_W.
module emi_cfg_regs #(
    parameter int WS_W  = 4,
    parameter int NSEG  = 4,
    parameter int CFG_W = NSEG * WS_W,
    parameter int CTL_W = NSEG + 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CFG_W-1:0]           wdata,
    input  logic                       wait_we,
    input  logic                       ctl_we,
    output logic [NSEG-1:0][WS_W-1:0]  seg_ws,
    output logic [NSEG:0]              dly_o,
    output logic                       psel_pol_o
);

    logic [CFG_W-1:0] wait_q;
    logic [CTL_W-1:0] ctl_q;

    // Load the wait-count register on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (wait_we) begin
            wait_q <= wdata;
        end
    end

    // Load the delay/polarity control register on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= wdata[CTL_W-1:0];
        end
    end

    // Split the wait register into one field per segment.
    for (genvar g = 0; g < NSEG; g++) begin : g_ws
        assign seg_ws[g] = wait_q[g*WS_W +: WS_W];
    end

    assign dly_o      = ctl_q[NSEG:0];
    assign psel_pol_o = ctl_q[NSEG+1];

endmodule

// File: rtl/emi_seg_decode.sv
`timescale 1ns/1ps
// Memory-map decode of one request into a segment and a peripheral hit.
// Assumes X space is always external ROM and that PSEL_ADDR lies in the
// I/O window.
module emi_seg_decode
    import emi_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] IO_BASE    = 16'h4000,
    parameter logic [ADDR_W-1:0] IO_LAST    = 16'h40FF,
    parameter logic [ADDR_W-1:0] HIRAM_BASE = 16'h8000,
    parameter logic [ADDR_W-1:0] PSEL_ADDR  = 16'h40F0
) (
    input  space_e            space_i,
    input  logic [ADDR_W-1:0] addr_i,
    output seg_e              seg_o,
    output logic              psel_hit_o
);

    // Choose the segment from the space and the address window.
    always_comb begin
        if (space_i == SP_X) begin
            seg_o = SEG_ROM;
        end else if (addr_i >= HIRAM_BASE) begin
            seg_o = SEG_HIRAM;
        end else if ((addr_i >= IO_BASE) && (addr_i <= IO_LAST)) begin
            seg_o = SEG_IO;
        end else begin
            seg_o = SEG_LORAM;
        end
        psel_hit_o = (space_i == SP_Y) && (addr_i == PSEL_ADDR);
    end

endmodule

// File: rtl/emi_seq_ctrl.sv
`timescale 1ns/1ps
// Access sequencer: picks which space owns the bus, latches its request,
// and counts the wait states. X wins a tie. When an access ends, the
// other space starts at once if it is waiting.
// Assumes a requester holds its request steady until its ready cycle.
module emi_seq_ctrl
    import emi_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 16,
    parameter int                WS_W       = 4,
    parameter int                NSEG       = 4,
    parameter logic [ADDR_W-1:0] IO_BASE    = 16'h4000,
    parameter logic [ADDR_W-1:0] IO_LAST    = 16'h40FF,
    parameter logic [ADDR_W-1:0] HIRAM_BASE = 16'h8000,
    parameter logic [ADDR_W-1:0] PSEL_ADDR  = 16'h40F0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      x_req,
    input  logic                      x_we,
    input  logic [ADDR_W-1:0]         x_addr,
    input  logic [DATA_W-1:0]         x_wdata,
    input  logic                      y_req,
    input  logic                      y_we,
    input  logic [ADDR_W-1:0]         y_addr,
    input  logic [DATA_W-1:0]         y_wdata,
    input  logic [NSEG-1:0][WS_W-1:0] seg_ws,
    output logic                      busy_o,
    output logic                      done_o,
    output space_e                    owner_o,
    output seg_e                      seg_o,
    output logic                      psel_hit_o,
    output logic [ADDR_W-1:0]         addr_o,
    output logic                      we_o,
    output logic [DATA_W-1:0]         wdata_o
);

    typedef enum logic {ST_IDLE, ST_BUSY} st_e;

    st_e               st_q;
    space_e            own_q;
    logic [WS_W-1:0]   cnt_q;
    seg_e              seg_q;
    logic              phit_q;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;

    logic              cand_valid;
    space_e            cand_sp;
    logic [ADDR_W-1:0] cand_addr;
    logic              cand_we;
    logic [DATA_W-1:0] cand_wdata;
    seg_e              cand_seg;
    logic              cand_phit;
    logic              last_cycle;

    assign last_cycle = (st_q == ST_BUSY) && (cnt_q == '0);

    // Pick the next owner: X first from idle, otherwise hand over to the other space.
    always_comb begin
        cand_valid = 1'b0;
        cand_sp    = SP_X;
        if (st_q == ST_IDLE) begin
            if (x_req) begin
                cand_valid = 1'b1;
                cand_sp    = SP_X;
            end else if (y_req) begin
                cand_valid = 1'b1;
                cand_sp    = SP_Y;
            end
        end else if (last_cycle) begin
            if ((own_q == SP_X) && y_req) begin
                cand_valid = 1'b1;
                cand_sp    = SP_Y;
            end else if ((own_q == SP_Y) && x_req) begin
                cand_valid = 1'b1;
                cand_sp    = SP_X;
            end
        end
        cand_addr  = (cand_sp == SP_X) ? x_addr  : y_addr;
        cand_we    = (cand_sp == SP_X) ? x_we    : y_we;
        cand_wdata = (cand_sp == SP_X) ? x_wdata : y_wdata;
    end

    emi_seg_decode #(
        .ADDR_W     (ADDR_W),
        .IO_BASE    (IO_BASE),
        .IO_LAST    (IO_LAST),
        .HIRAM_BASE (HIRAM_BASE),
        .PSEL_ADDR  (PSEL_ADDR)
    ) u_decode (
        .space_i    (cand_sp),
        .addr_i     (cand_addr),
        .seg_o      (cand_seg),
        .psel_hit_o (cand_phit)
    );

    // Start a new access, count down wait states, or return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            own_q   <= SP_X;
            cnt_q   <= '0;
            seg_q   <= SEG_LORAM;
            phit_q  <= 1'b0;
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (cand_valid) begin
            st_q    <= ST_BUSY;
            own_q   <= cand_sp;
            cnt_q   <= seg_ws[cand_seg];
            seg_q   <= cand_seg;
            phit_q  <= cand_phit;
            addr_q  <= cand_addr;
            we_q    <= cand_we;
            wdata_q <= cand_wdata;
        end else if (st_q == ST_BUSY) begin
            if (cnt_q == '0) begin
                st_q <= ST_IDLE;
                we_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy_o     = (st_q == ST_BUSY);
    assign done_o     = last_cycle;
    assign owner_o    = own_q;
    assign seg_o      = seg_q;
    assign psel_hit_o = phit_q;
    assign addr_o     = addr_q;
    assign we_o       = we_q;
    assign wdata_o    = wdata_q;

endmodule

// File: rtl/emi_strobe_delay.sv
`timescale 1ns/1ps
// Optional half-cycle assertion delay for a set of active-low selects.
// A falling-edge copy of each select is ORed in while its delay bit is
// set. The select then asserts at mid-cycle and still releases on the
// rising edge. Assumes the raw selects come from rising-edge registers.
module emi_strobe_delay #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_n,
    input  logic [N-1:0] dly,
    output logic [N-1:0] out_n
);

    logic [N-1:0] fall_q;

    // Capture the raw selects on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            fall_q <= '1;
        end else begin
            fall_q <= raw_n;
        end
    end

    // Hold each delayed select inactive until its falling-edge copy catches up.
    for (genvar g = 0; g < N; g++) begin : g_dly
        assign out_n[g] = raw_n[g] | (dly[g] & fall_q[g]);
    end

endmodule

// File: rtl/emi_seq.sv
`timescale 1ns/1ps
// External memory interface sequencer top. It shares one external
// address/data bus between the X and Y request spaces, drives the
// segment enables and peripheral select, and drives the data bus only
// during writes. Assumes the bus device answers in the access window.
module emi_seq
    import emi_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 16,
    parameter int                WS_W       = 4,
    parameter int                NSEG       = 4,
    parameter logic [ADDR_W-1:0] IO_BASE    = 16'h4000,
    parameter logic [ADDR_W-1:0] IO_LAST    = 16'h40FF,
    parameter logic [ADDR_W-1:0] HIRAM_BASE = 16'h8000,
    parameter logic [ADDR_W-1:0] PSEL_ADDR  = 16'h40F0,
    localparam int               CFG_W      = NSEG * WS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              cfg_wait_we,
    input  logic              cfg_ctl_we,
    input  logic              x_req,
    input  logic              x_we,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [DATA_W-1:0] x_wdata,
    output logic [DATA_W-1:0] x_rdata,
    output logic              x_rdy,
    input  logic              y_req,
    input  logic              y_we,
    input  logic [ADDR_W-1:0] y_addr,
    input  logic [DATA_W-1:0] y_wdata,
    output logic [DATA_W-1:0] y_rdata,
    output logic              y_rdy,
    output logic [ADDR_W-1:0] ext_addr,
    inout  wire  [DATA_W-1:0] ext_data,
    output logic              ext_we_n,
    output logic [NSEG-1:0]   seg_en_n,
    output logic              psel
);

    logic [NSEG-1:0][WS_W-1:0] seg_ws;
    logic [NSEG:0]             dly;
    logic                      psel_pol;
    logic                      busy;
    logic                      done;
    space_e                    owner;
    seg_e                      seg_q;
    logic                      psel_hit_q;
    logic [ADDR_W-1:0]         addr_q;
    logic                      we_q;
    logic [DATA_W-1:0]         wdata_q;
    logic [NSEG:0]             raw_n;
    logic [NSEG:0]             strb_n;
    logic                      drive_bus;

    emi_cfg_regs #(
        .WS_W  (WS_W),
        .NSEG  (NSEG)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wdata      (cfg_wdata),
        .wait_we    (cfg_wait_we),
        .ctl_we     (cfg_ctl_we),
        .seg_ws     (seg_ws),
        .dly_o      (dly),
        .psel_pol_o (psel_pol)
    );

    emi_seq_ctrl #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .WS_W       (WS_W),
        .NSEG       (NSEG),
        .IO_BASE    (IO_BASE),
        .IO_LAST    (IO_LAST),
        .HIRAM_BASE (HIRAM_BASE),
        .PSEL_ADDR  (PSEL_ADDR)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .x_req      (x_req),
        .x_we       (x_we),
        .x_addr     (x_addr),
        .x_wdata    (x_wdata),
        .y_req      (y_req),
        .y_we       (y_we),
        .y_addr     (y_addr),
        .y_wdata    (y_wdata),
        .seg_ws     (seg_ws),
        .busy_o     (busy),
        .done_o     (done),
        .owner_o    (owner),
        .seg_o      (seg_q),
        .psel_hit_o (psel_hit_q),
        .addr_o     (addr_q),
        .we_o       (we_q),
        .wdata_o    (wdata_q)
    );

    // One undelayed active-low select per segment, active while that segment is in use.
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        assign raw_n[g] = !(busy && (int'(seg_q) == g));
    end
    assign raw_n[NSEG] = !(busy && psel_hit_q);

    emi_strobe_delay #(
        .N (NSEG + 1)
    ) u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_n (raw_n),
        .dly   (dly),
        .out_n (strb_n)
    );

    assign seg_en_n  = strb_n[NSEG-1:0];
    assign psel      = strb_n[NSEG] ^ psel_pol;

    assign drive_bus = busy && we_q;
    assign ext_we_n  = !drive_bus;
    assign ext_data  = drive_bus ? wdata_q : {DATA_W{1'bz}};
    assign ext_addr  = addr_q;

    assign x_rdy     = done && (owner == SP_X);
    assign y_rdy     = done && (owner == SP_Y);
    assign x_rdata   = ext_data;
    assign y_rdata   = ext_data;

endmodule

// File: rtl/emi_seq_checker.sv
`timescale 1ns/1ps
// Assertion checker for the sequencer, bound into every instance of the top.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module emi_seq_checker #(
    parameter int NSEG   = 4,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              x_rdy,
    input logic              y_rdy,
    input logic [NSEG-1:0]   seg_en_n,
    input logic              psel,
    input logic              psel_pol,
    input logic              ext_we_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              busy,
    input logic              done
);

    // R5: never two segments selected at once
    a_r5_one_segment: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~seg_en_n));

    // R5: only one space completes in a cycle
    a_r5_one_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !(x_rdy && y_rdy));

    // R4: after X completes the bus passes to Y or goes idle, never straight to X again
    a_r4_x_hands_over: assert property (@(posedge clk) disable iff (!rst_n)
        x_rdy |=> !x_rdy);

    // R4: after Y completes, Y is not served again back to back
    a_r4_y_hands_over: assert property (@(posedge clk) disable iff (!rst_n)
        y_rdy |=> !y_rdy);

    // R2: peripheral select only ever appears alongside the I/O enable
    a_r2_psel_in_io: assert property (@(posedge clk) disable iff (!rst_n)
        (psel == psel_pol) |-> !seg_en_n[1]);

    // R7: a write strobe only appears while a segment is selected
    a_r7_write_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_we_n |-> (seg_en_n != '1));

    // R9: address holds between the cycles of one access
    a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(ext_addr));

endmodule

bind emi_seq emi_seq_checker #(
    .NSEG   (NSEG),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .x_rdy    (x_rdy),
    .y_rdy    (y_rdy),
    .seg_en_n (seg_en_n),
    .psel     (psel),
    .psel_pol (psel_pol),
    .ext_we_n (ext_we_n),
    .ext_addr (ext_addr),
    .busy     (busy),
    .done     (done)
);

// File: tb/emi_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected accesses, a monitor
// compares each completed access seen on the external bus.
module emi_seq_bench;

    localparam logic [15:0] KEY = 16'hA5C3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n       = 1'b0;
    logic [15:0] cfg_wdata   = '0;
    logic        cfg_wait_we = 1'b0;
    logic        cfg_ctl_we  = 1'b0;
    logic        x_req = 1'b0, x_we = 1'b0;
    logic [15:0] x_addr = '0, x_wdata = '0;
    logic        y_req = 1'b0, y_we = 1'b0;
    logic [15:0] y_addr = '0, y_wdata = '0;
    logic [15:0] x_rdata, y_rdata, ext_addr;
    logic        x_rdy, y_rdy, ext_we_n, psel;
    logic [3:0]  seg_en_n;
    wire  [15:0] ext_data;

    // External device model: answers every read with address xor KEY.
    assign ext_data = ext_we_n ? (ext_addr ^ KEY) : 16'bz;

    emi_seq u_emi_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wdata(cfg_wdata),
        .cfg_wait_we(cfg_wait_we), .cfg_ctl_we(cfg_ctl_we),
        .x_req(x_req), .x_we(x_we), .x_addr(x_addr), .x_wdata(x_wdata),
        .x_rdata(x_rdata), .x_rdy(x_rdy),
        .y_req(y_req), .y_we(y_we), .y_addr(y_addr), .y_wdata(y_wdata),
        .y_rdata(y_rdata), .y_rdy(y_rdy),
        .ext_addr(ext_addr), .ext_data(ext_data), .ext_we_n(ext_we_n),
        .seg_en_n(seg_en_n), .psel(psel)
    );

    typedef struct {
        bit          sp;
        bit          we;
        logic [15:0] addr;
        logic [15:0] wdata;
        int          seg;
        int          ws;
        bit          phit;
        bit          pol;
        bit          dseg;
        bit          dpsel;
        bit          chained;
    } item_t;

    item_t       sb[$];
    int          n_cmp = 0, n_bad = 0;
    longint      cyc = 0;
    logic [15:0] cur_wait = '0;
    logic [5:0]  cur_ctl  = '0;
    bit          x_done = 0, y_done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference decode from R1.
    function automatic int ref_seg(bit sp, logic [15:0] a);
        if (!sp) return 3;
        if (a >= 16'h8000) return 2;
        if (a >= 16'h4000 && a <= 16'h40FF) return 1;
        return 0;
    endfunction

    function automatic item_t mk(bit sp, bit we, logic [15:0] a, logic [15:0] d, bit ch);
        item_t it;
        it.sp = sp; it.we = we; it.addr = a; it.wdata = d; it.chained = ch;
        it.seg   = ref_seg(sp, a);
        it.ws    = int'(cur_wait[it.seg*4 +: 4]);
        it.phit  = sp && (a == 16'h40F0);
        it.pol   = cur_ctl[5];
        it.dseg  = cur_ctl[it.seg];
        it.dpsel = cur_ctl[4];
        return it;
    endfunction

    task automatic do_cfg(input logic [15:0] w, input logic [5:0] c);
        @(posedge clk); #1;
        cfg_wdata = w; cfg_wait_we = 1'b1;
        @(posedge clk); #1;
        cfg_wait_we = 1'b0; cfg_wdata = {10'd0, c}; cfg_ctl_we = 1'b1;
        @(posedge clk); #1;
        cfg_ctl_we = 1'b0;
        cur_wait = w; cur_ctl = c;
    endtask

    task automatic single(input bit sp, input bit we, input logic [15:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        sb.push_back(mk(sp, we, a, d, 1'b0));
        if (!sp) begin
            x_done = 0; x_req = 1; x_we = we; x_addr = a; x_wdata = d;
        end else begin
            y_done = 0; y_req = 1; y_we = we; y_addr = a; y_wdata = d;
        end
        while (!(sp ? y_done : x_done)) begin @(posedge clk); #1; end
        if (!sp) x_req = 0; else y_req = 0;
    endtask

    task automatic pair(input bit xw, input logic [15:0] xa, input logic [15:0] xd,
                        input bit yw, input logic [15:0] ya, input logic [15:0] yd);
        @(posedge clk); #1;
        sb.push_back(mk(1'b0, xw, xa, xd, 1'b0));
        sb.push_back(mk(1'b1, yw, ya, yd, 1'b1));
        x_done = 0; y_done = 0;
        x_req = 1; x_we = xw; x_addr = xa; x_wdata = xd;
        y_req = 1; y_we = yw; y_addr = ya; y_wdata = yd;
        while (!(x_done && y_done)) begin
            @(posedge clk); #1;
            if (x_done) x_req = 0;
            if (y_done) y_req = 0;
        end
        x_req = 0; y_req = 0;
    endtask

    // Monitor: sample after the rising edge (A) and after the falling edge (B).
    initial begin
        item_t       it;
        logic [3:0]  enA, enB, mask, prev_mask, fA;
        logic        pselA, pselB, fpA, rx, ry, weA;
        logic [15:0] addrA, dataA, rdA;
        int          run;
        longint      last_done;
        prev_mask = '0; run = 0; fA = '1; fpA = 1'b0; last_done = 0;
        forever begin
            @(posedge clk); #2;
            enA = seg_en_n; pselA = psel; rx = x_rdy; ry = y_rdy;
            addrA = ext_addr; dataA = ext_data; weA = ext_we_n;
            rdA = rx ? x_rdata : y_rdata;
            #2;
            enB = seg_en_n; pselB = psel;
            if (rst_n) begin
                mask = ~enB;
                if (mask != '0) begin
                    if (mask != prev_mask) begin
                        run = 1; fA = enA; fpA = pselA;
                    end else begin
                        run++;
                    end
                end
                prev_mask = (rx || ry) ? 4'd0 : mask;
                if (rx || ry) begin
                    chk("R5 single ready", {31'd0, rx && ry}, 32'd0);
                    if (sb.size() == 0) begin
                        n_cmp++; n_bad++;
                        $display("FAIL R5 unexpected ready: actual 1 expected 0");
                    end else begin
                        it = sb.pop_front();
                        chk("R4 serving space", {31'd0, ry}, {31'd0, it.sp});
                        chk("R1 segment enable", {28'd0, mask}, 32'd1 << it.seg);
                        chk("R3 access length", run, 1 + it.ws);
                        chk("R6 segment first half", {31'd0, fA[it.seg]}, {31'd0, it.dseg});
                        chk("R9 address", {16'd0, addrA}, {16'd0, it.addr});
                        chk("R7 write strobe", {31'd0, weA}, {31'd0, !it.we});
                        if (it.we)
                            chk("R7 write data on bus", {16'd0, dataA}, {16'd0, it.wdata});
                        else
                            chk("R7 read data", {16'd0, rdA}, {16'd0, it.addr ^ KEY});
                        chk("R2 peripheral select", {31'd0, pselB == it.pol}, {31'd0, it.phit});
                        chk("R6 select first half", {31'd0, fpA == it.pol},
                            {31'd0, it.phit && !it.dpsel});
                        if (it.chained)
                            chk("R4 follow-on cycle", 32'(cyc - last_done), 1 + it.ws);
                    end
                    last_done = cyc;
                    if (rx) x_done = 1;
                    if (ry) y_done = 1;
                end
            end
        end
    end

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2;
        // R8: reset state
        chk("R8 enables idle", {28'd0, seg_en_n}, 32'hF);
        chk("R8 select idle", {31'd0, psel}, 32'd1);
        chk("R8 write strobe idle", {31'd0, ext_we_n}, 32'd1);
        chk("R8 x ready low", {31'd0, x_rdy}, 32'd0);
        chk("R8 y ready low", {31'd0, y_rdy}, 32'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R8 defaults: zero waits, no delays
        single(1'b0, 1'b0, 16'h0123, 16'h0);
        single(1'b1, 1'b0, 16'h40F0, 16'h0);
        // R4 with zero waits: Y one cycle behind X
        pair(1'b0, 16'h0200, 16'h0, 1'b0, 16'h0010, 16'h0);

        // R3: distinct wait counts per segment
        do_cfg(16'h2314, 6'b000000);
        single(1'b1, 1'b0, 16'h0050, 16'h0);
        single(1'b1, 1'b0, 16'h4000, 16'h0);
        single(1'b1, 1'b0, 16'h9000, 16'h0);
        single(1'b0, 1'b0, 16'hF000, 16'h0);
        single(1'b1, 1'b1, 16'h8000, 16'hBEEF);
        single(1'b1, 1'b1, 16'h40F0, 16'h1357);
        // R1 boundaries
        single(1'b1, 1'b0, 16'h3FFF, 16'h0);
        single(1'b1, 1'b0, 16'h40FF, 16'h0);
        single(1'b1, 1'b0, 16'h4100, 16'h0);
        single(1'b1, 1'b0, 16'h7FFF, 16'h0);
        single(1'b1, 1'b0, 16'hFFFF, 16'h0);
        // R4 with waits
        pair(1'b0, 16'h0777, 16'h0, 1'b1, 16'h0001, 16'h2468);

        // R6/R2: low RAM, high RAM and select delayed, select active-high
        do_cfg(16'h0000, 6'b110101);
        single(1'b1, 1'b0, 16'h40F0, 16'h0);
        single(1'b1, 1'b0, 16'h0002, 16'h0);
        single(1'b1, 1'b0, 16'h8001, 16'h0);
        single(1'b0, 1'b0, 16'h0003, 16'h0);
        single(1'b1, 1'b0, 16'h4001, 16'h0);
        pair(1'b0, 16'h0004, 16'h0, 1'b0, 16'h0005, 16'h0);

        // R6: I/O and ROM delayed, select undelayed and active-low, with waits
        do_cfg(16'h2314, 6'b001010);
        single(1'b1, 1'b1, 16'h40F0, 16'h5A5A);
        single(1'b0, 1'b0, 16'h1111, 16'h0);
        single(1'b1, 1'b0, 16'h0033, 16'h0);
        pair(1'b0, 16'h2222, 16'h0, 1'b0, 16'hC000, 16'h0);

        repeat (5) @(posedge clk);
        chk("R5 scoreboard drained", sb.size(), 32'd0);
        summary();
        $finish;
    end

endmodule